// File: doc/BRIEF.md
# SYNC-driven exposure controller

This block sits inside a CCD timing generator in master mode. It turns an external, asynchronous SYNC level into one-cycle strobes for the pixel clock domain. The strobes reset the horizontal and vertical counters and reset or advance the field designator. The block also raises the masks and holds that suspend or trim vertical and horizontal output activity while an exposure is in progress. SYNC idles high. An exposure interval is the low phase of SYNC.

Three modes exist. In the normal mode, only the rising SYNC edge matters. The two enhanced modes are selected by an enable input. In both of them, each SYNC edge resets the counters and advances the field designator. Between a detected falling edge and the next detected rising edge, register updates are frozen and SCP0 is forced low. One enhanced variant holds the V/VSG outputs still. The other lets them run and can mask HD instead. The V-mask enable chooses between the two variants. All outputs are registered.

Top module: `sync_exposure_ctrl`

## Requirements
- R1: A SYNC level that is stable before rising clock edge k shows its edge effect in the outputs registered at edge k+2. This comes from the two synchronizer stages plus the output register.
- R2: With `enh_en` low, a detected rising SYNC edge gives one cycle of `cnt_rst` and `field_rst`. A falling edge gives no strobe, and every mask and hold stays low.
- R3: With `enh_en` high, both the falling and the rising SYNC edge each give one cycle of `cnt_rst`.
- R4: With `enh_en` high, each detected edge gives one cycle of `field_inc`, unless `single_field` is high, in which case `field_inc` stays low. `field_rst` stays low in the enhanced modes.
- R5: With `enh_en` high, `upd_hold` and `scp0_low` are high from the cycle of the falling-edge strobe up to, but not including, the cycle of the rising-edge strobe.
- R6: The hold-V variant applies when `enh_en`=1 and `mask_v_en`=1. Here `v_hold` is high throughout the interval and `hd_mask` stays low.
- R7: The run-V variant applies when `enh_en`=1 and `mask_v_en`=0. Here `v_hold` stays low and `hd_mask` equals `mask_hd_en` throughout the interval.
- R8: In both enhanced variants, `vd_mask` equals `mask_vd_en` throughout the interval and is low outside it.
- R9: While `rst` is high, all outputs are low. The synchronizer is preset to the idle-high level, so a high SYNC at reset release produces no edge.
- R10: Dropping `enh_en` during an interval ends it. All masks and holds are low in the next registered cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous SYNC level, idle high |
| enh_en | input | 1 | Enables the enhanced (dual-edge) modes |
| mask_v_en | input | 1 | Selects the hold-V variant when set |
| mask_vd_en | input | 1 | Enables VD masking in the interval |
| mask_hd_en | input | 1 | Enables HD masking in the run-V variant |
| single_field | input | 1 | MODE outputs only one field; suppresses field advance |
| cnt_rst | output | 1 | One-cycle H/V counter reset strobe |
| field_rst | output | 1 | One-cycle field designator reset (normal mode) |
| field_inc | output | 1 | One-cycle field designator advance (enhanced modes) |
| v_hold | output | 1 | Suspend V/VSG at sequence-0 start polarity |
| vd_mask | output | 1 | Mask VD pulses |
| hd_mask | output | 1 | Mask HD pulses |
| upd_hold | output | 1 | Freeze VD-latched register updates |
| scp0_low | output | 1 | Force SCP0 low |

## Verification
The falling-edge strobes (`cnt_rst`, `field_inc`) and the start of the interval masks must appear in the same registered cycle. Likewise, the rising-edge strobe must coincide with the cycle in which the masks drop. The bench provokes these collisions with one-cycle SYNC pulses and with configuration changes timed to land on the same edge as a SYNC transition, including dropping `enh_en` mid-interval. A behavioural model holds the sampled SYNC history in a queue and derives the expected strobe and mask values. Every output is compared against it on every clock.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;

  typedef enum logic [1:0] {
    SM_NORMAL = 2'd1,
    SM_HOLD_V = 2'd2,
    SM_RUN_V  = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sync_edge_t;

  typedef struct packed {
    logic v_hold;
    logic vd_mask;
    logic hd_mask;
    logic upd_hold;
    logic scp0_low;
  } sync_mask_t;

  function automatic sync_mode_e decode_mode(input logic enh, input logic mask_v);
    if (!enh)       return SM_NORMAL;
    else if (mask_v) return SM_HOLD_V;
    else            return SM_RUN_V;
  endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect
  import sync_ctrl_pkg::*;
#(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       async_in,
  output sync_edge_t edge_o
);
  logic [STAGES-1:0] meta_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) meta_q[0] <= IDLE_LEVEL;
    else     meta_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) meta_q[g] <= IDLE_LEVEL;
      else     meta_q[g] <= meta_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDLE_LEVEL;
    else     last_q <= meta_q[STAGES-1];
  end

  assign edge_o.rise =  meta_q[STAGES-1] & ~last_q;
  assign edge_o.fall = ~meta_q[STAGES-1] &  last_q;
endmodule

// File: rtl/sync_interval_track.sv
module sync_interval_track
  import sync_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enh_en,
  input  sync_edge_t edge_i,
  output logic       active_next
);
  logic active_q;

  always_comb begin
    if (!enh_en)          active_next = 1'b0;
    else if (edge_i.fall) active_next = 1'b1;
    else if (edge_i.rise) active_next = 1'b0;
    else                  active_next = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active_next;
  end
endmodule

// File: rtl/sync_mask_gen.sv
module sync_mask_gen
  import sync_ctrl_pkg::*;
(
  input  sync_mode_e mode,
  input  logic       active,
  input  logic       mask_vd_en,
  input  logic       mask_hd_en,
  output sync_mask_t mask_o
);
  always_comb begin
    mask_o = '0;
    case (mode)
      SM_HOLD_V: begin
        mask_o.v_hold  = active;
        mask_o.vd_mask = active & mask_vd_en;
      end
      SM_RUN_V: begin
        mask_o.vd_mask = active & mask_vd_en;
        mask_o.hd_mask = active & mask_hd_en;
      end
      default: mask_o = '0;
    endcase
    mask_o.upd_hold = active & (mode != SM_NORMAL);
    mask_o.scp0_low = active & (mode != SM_NORMAL);
  end
endmodule

// File: rtl/sync_exposure_ctrl.sv
module sync_exposure_ctrl
  import sync_ctrl_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic SYNC_IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic enh_en,
  input  logic mask_v_en,
  input  logic mask_vd_en,
  input  logic mask_hd_en,
  input  logic single_field,
  output logic cnt_rst,
  output logic field_rst,
  output logic field_inc,
  output logic v_hold,
  output logic vd_mask,
  output logic hd_mask,
  output logic upd_hold,
  output logic scp0_low
);
  sync_edge_t edge_w;
  logic       active_w;
  sync_mode_e mode_w;
  sync_mask_t mask_w;
  logic       any_edge;

  sync_edge_detect #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(SYNC_IDLE)) i_edge (
    .clk(clk), .rst(rst), .async_in(sync_in), .edge_o(edge_w)
  );

  sync_interval_track i_track (
    .clk(clk), .rst(rst), .enh_en(enh_en), .edge_i(edge_w), .active_next(active_w)
  );

  assign mode_w   = decode_mode(enh_en, mask_v_en);
  assign any_edge = edge_w.rise | edge_w.fall;

  sync_mask_gen i_mask (
    .mode(mode_w), .active(active_w), .mask_vd_en(mask_vd_en),
    .mask_hd_en(mask_hd_en), .mask_o(mask_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_rst   <= 1'b0;
      field_rst <= 1'b0;
      field_inc <= 1'b0;
      v_hold    <= 1'b0;
      vd_mask   <= 1'b0;
      hd_mask   <= 1'b0;
      upd_hold  <= 1'b0;
      scp0_low  <= 1'b0;
    end else begin
      if (mode_w == SM_NORMAL) begin
        cnt_rst   <= edge_w.rise;
        field_rst <= edge_w.rise;
        field_inc <= 1'b0;
      end else begin
        cnt_rst   <= any_edge;
        field_rst <= 1'b0;
        field_inc <= any_edge & ~single_field;
      end
      v_hold   <= mask_w.v_hold;
      vd_mask  <= mask_w.vd_mask;
      hd_mask  <= mask_w.hd_mask;
      upd_hold <= mask_w.upd_hold;
      scp0_low <= mask_w.scp0_low;
    end
  end
endmodule

// File: rtl/sync_exposure_ctrl_chk.sv
module sync_exposure_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic enh_en,
  input logic cnt_rst,
  input logic field_rst,
  input logic field_inc,
  input logic v_hold,
  input logic vd_mask,
  input logic hd_mask,
  input logic upd_hold
);
  AST_FRST_WITH_CNT: assert property (@(posedge clk) disable iff (rst) field_rst |-> cnt_rst); // R2
  AST_FINC_WITH_CNT: assert property (@(posedge clk) disable iff (rst) field_inc |-> cnt_rst); // R4
  AST_FIELD_EXCL: assert property (@(posedge clk) disable iff (rst) !(field_inc && field_rst)); // R4
  AST_INTERVAL_STARTS_ON_STROBE: assert property (@(posedge clk) disable iff (rst) $rose(upd_hold) |-> cnt_rst); // R5
  AST_VHOLD_IN_INTERVAL: assert property (@(posedge clk) disable iff (rst) v_hold |-> upd_hold); // R6
  AST_HD_ONLY_RUNV: assert property (@(posedge clk) disable iff (rst) hd_mask |-> (upd_hold && !v_hold)); // R7
  AST_VD_IN_INTERVAL: assert property (@(posedge clk) disable iff (rst) vd_mask |-> upd_hold); // R8
  AST_NORMAL_NO_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(enh_en) |-> !upd_hold); // R10
endmodule

bind sync_exposure_ctrl sync_exposure_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .enh_en(enh_en), .cnt_rst(cnt_rst), .field_rst(field_rst),
  .field_inc(field_inc), .v_hold(v_hold), .vd_mask(vd_mask), .hd_mask(hd_mask),
  .upd_hold(upd_hold)
);

// File: tb/test_sync_exposure_ctrl.sv
`timescale 1ns/1ps
module test_sync_exposure_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b1;
  logic enh_en = 1'b0, mask_v_en = 1'b0, mask_vd_en = 1'b1, mask_hd_en = 1'b1;
  logic single_field = 1'b0;
  logic cnt_rst, field_rst, field_inc, v_hold, vd_mask, hd_mask, upd_hold, scp0_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_exposure_ctrl i_sync_exposure_ctrl (
    .clk(clk), .rst(rst), .sync_in(sync_in), .enh_en(enh_en), .mask_v_en(mask_v_en),
    .mask_vd_en(mask_vd_en), .mask_hd_en(mask_hd_en), .single_field(single_field),
    .cnt_rst(cnt_rst), .field_rst(field_rst), .field_inc(field_inc), .v_hold(v_hold),
    .vd_mask(vd_mask), .hd_mask(hd_mask), .upd_hold(upd_hold), .scp0_low(scp0_low)
  );

  // Behavioural reference: history of SYNC samples taken at each clock edge
  bit hist[$];
  bit in_exposure;
  bit e_cnt, e_frst, e_finc, e_vh, e_vd, e_hd, e_upd, e_scp;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b1, 1'b1, 1'b1};
      in_exposure = 1'b0;
      {e_cnt, e_frst, e_finc, e_vh, e_vd, e_hd, e_upd, e_scp} = '0;
    end else begin
      bit older, newer, went_up, went_down;
      older = hist[0];
      newer = hist[1];
      went_up   = newer && !older;
      went_down = !newer && older;
      if (!enh_en) begin
        in_exposure = 1'b0;
        e_cnt = went_up; e_frst = went_up; e_finc = 1'b0;
      end else begin
        if (went_down) in_exposure = 1'b1;
        else if (went_up) in_exposure = 1'b0;
        e_cnt = went_up || went_down;
        e_frst = 1'b0;
        e_finc = (went_up || went_down) && !single_field;
      end
      e_upd = in_exposure;
      e_scp = in_exposure;
      e_vh  = in_exposure && mask_v_en;
      e_vd  = in_exposure && mask_vd_en;
      e_hd  = in_exposure && !mask_v_en && mask_hd_en;
      void'(hist.pop_front());
      hist.push_back(sync_in);
    end
  end

  task automatic chk(input string req, input string nm, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R3", "cnt_rst",   cnt_rst,   e_cnt);
      chk("R2", "field_rst", field_rst, e_frst);
      chk("R4", "field_inc", field_inc, e_finc);
      chk("R5", "upd_hold",  upd_hold,  e_upd);
      chk("R5", "scp0_low",  scp0_low,  e_scp);
      chk("R6", "v_hold",    v_hold,    e_vh);
      chk("R7", "hd_mask",   hd_mask,   e_hd);
      chk("R8", "vd_mask",   vd_mask,   e_vd);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic pulse(input int low_len, input int high_len);
    sync_in = 1'b0; tick(low_len);
    sync_in = 1'b1; tick(high_len);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    tick(3);
    @(negedge clk);
    checks++;
    if ({cnt_rst, field_rst, field_inc, v_hold, vd_mask, hd_mask, upd_hold, scp0_low} !== 8'h00) begin
      errors++;
      $display("FAIL R9 reset outputs: actual=%b expected=00000000",
               {cnt_rst, field_rst, field_inc, v_hold, vd_mask, hd_mask, upd_hold, scp0_low});
    end
    #3;
    rst = 1'b0;
    tick(6);   // R9: idle-high SYNC at release gives no edge (compared every clock)

    // R2: normal mode, long and one-cycle pulses
    pulse(5, 6);
    pulse(1, 6);

    // R1: latency check in hold-V variant
    enh_en = 1'b1; mask_v_en = 1'b1; tick(4);
    sync_in = 1'b0; tick(2);
    @(negedge clk);
    checks++;
    if (cnt_rst !== 1'b0) begin
      errors++; $display("FAIL R1 early strobe: actual=%0b expected=0", cnt_rst);
    end
    #3; tick(1);
    @(negedge clk);
    checks++;
    if (cnt_rst !== 1'b1) begin
      errors++; $display("FAIL R1 strobe at edge k+2: actual=%0b expected=1", cnt_rst);
    end
    #3; tick(5);
    sync_in = 1'b1; tick(6);

    // R3 R4 R6: hold-V with field advance, then single field
    pulse(7, 5);
    single_field = 1'b1; pulse(4, 5); single_field = 1'b0;
    pulse(1, 4);
    pulse(1, 1); pulse(1, 5);

    // R7 R8: run-V variant with HD and VD mask options
    mask_v_en = 1'b0;
    pulse(6, 5);
    mask_hd_en = 1'b0; pulse(5, 5);
    mask_vd_en = 1'b0; mask_hd_en = 1'b1; pulse(5, 5);
    mask_vd_en = 1'b1;

    // R10: drop enable mid-interval, restore, then finish pulse
    sync_in = 1'b0; tick(5);
    enh_en = 1'b0; tick(3);
    enh_en = 1'b1; tick(3);
    sync_in = 1'b1; tick(6);

    // Configuration change landing on the edge cycle
    sync_in = 1'b0; tick(2);
    mask_v_en = 1'b1; tick(4);
    sync_in = 1'b1; tick(2);
    single_field = 1'b1; tick(4);
    single_field = 1'b0;

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] < 4'd3) sync_in = ~sync_in;
      if (c % 41 == 0) begin
        enh_en = lfsr[7] | lfsr[8];
        mask_v_en = lfsr[9];
        mask_vd_en = lfsr[10];
        mask_hd_en = lfsr[11];
        single_field = lfsr[12] & lfsr[13];
      end
      tick(1);
    end
    sync_in = 1'b1; tick(6);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule